// File: doc/BRIEF.md
# Transmit Byte Queue with Level Interrupt

This block sits between a CPU register bus and the bit engine of a serial controller. The CPU pushes data bytes into a 16-entry queue through a data write port. The serial engine takes them out in order through a ready/valid handshake. One 16-bit control/status word carries several fields:

- a global queue-mode enable
- a queue run/reset control
- the live byte count
- a sticky interrupt flag with a write-one clear strobe
- an interrupt enable
- a 5-bit threshold

The flag is raised whenever the queue is running and holds no more bytes than the threshold. It stays raised until software clears it. While the run control is 0, the queue is held empty with its pointers at zero. Because of this, the flag fires as soon as the queue is released and enabled, and software clears it afterwards. The interrupt output is the flag gated by the enable.

Top module: `txq_ctl`

## Requirements
- R1: After reset the control word reads 0x0000, `irq` is 0 and `pop_valid` is 0.
- R2: Control word layout: bit 15 reads 0; bit 14 mode enable (R/W); bit 13 run (R/W, 0 holds the queue in reset); bits 12:8 byte count (read-only); bit 7 flag (read-only); bit 6 clear strobe (reads 0); bit 5 interrupt enable (R/W); bits 4:0 threshold (R/W).
- R3: The count rises by one per accepted data write and falls by one per completed pop. It never exceeds 16. A data write while the count is 16 is dropped.
- R4: Bytes leave on `pop_data` in the order they were written. A pop and a push in the same cycle leave the count unchanged.
- R5: While the mode enable is 0, data writes are ignored, `pop_valid` is 0, and the count and the stored bytes are kept.
- R6: While the run bit is 0, the count is forced to 0 one cycle later, stored bytes are discarded, data writes are ignored, and `pop_valid` is 0.
- R7: The flag is set one cycle after any cycle in which mode enable and run are both 1 and count ≤ threshold. This includes right after the queue is released from reset.
- R8: Writing 1 to bit 6 clears the flag when the set condition is false. Writing 0 to bit 6 leaves the flag unchanged.
- R9: When a clear strobe and the set condition occur in the same cycle, the flag stays 1.
- R10: `irq` is 1 exactly when the flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wen | input | 1 | Control word write strobe |
| csr_wdata | input | 16 | Control word write data |
| csr_rdata | output | 16 | Control word read value |
| dat_wen | input | 1 | Data byte write strobe |
| dat_wdata | input | 8 | Data byte to enqueue |
| pop_valid | output | 1 | A byte is available to the serial engine |
| pop_data | output | 8 | Oldest byte in the queue |
| pop_ready | input | 1 | Serial engine takes the byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the collision between the clear strobe and a live set condition. The flag must survive it, whereas a clear issued after the condition has ended must take effect. The stimulus first enables the queue with a threshold of zero, so the condition holds on an empty queue, and issues a clear there. It then pushes one byte so the condition ends and clears again. A write with bit 6 at 0 in between shows that a zero strobe has no effect. Overflow is reached by filling all sixteen entries and pushing once more. Draining the queue then shows the extra byte never entered.

// File: rtl/txq_ctl.sv
module txq_ctl #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_wen,
  input  logic [15:0]   csr_wdata,
  output logic [15:0]   csr_rdata,
  input  logic          dat_wen,
  input  logic [DW-1:0] dat_wdata,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  input  logic          pop_ready,
  output logic          irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          mode_en, run_en, ie, flag;
  logic [4:0]    thr;
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [4:0]    cnt5;
  logic          active, full, push, pop, cond, clr;

  assign active    = mode_en & run_en;
  assign full      = (count == CW'(DEPTH));
  assign cnt5      = 5'(count);
  assign pop_valid = active & (count != '0);
  assign pop_data  = mem[rd_ptr];
  assign push      = active & dat_wen & ~full;
  assign pop       = pop_valid & pop_ready;
  assign cond      = active & (cnt5 <= thr);
  assign clr       = csr_wen & csr_wdata[6];
  assign irq       = flag & ie;
  assign csr_rdata = {1'b0, mode_en, run_en, cnt5, flag, 1'b0, ie, thr};

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= dat_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_en <= 1'b0;
      run_en  <= 1'b0;
      ie      <= 1'b0;
      thr     <= '0;
    end else if (csr_wen) begin
      mode_en <= csr_wdata[14];
      run_en  <= csr_wdata[13];
      ie      <= csr_wdata[5];
      thr     <= csr_wdata[4:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_en) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     flag <= 1'b0;
    else if (cond)  flag <= 1'b1;
    else if (clr)   flag <= 1'b0;
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r3_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && full && dat_wen && !pop) |=> count == $past(count));
  a_r5_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |-> !pop_valid);
  a_r6_held: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> count == '0);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cond |=> flag);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !cond && !clr) |=> flag);
endmodule

// File: tb/txq_ctl_test.sv
module txq_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_wen = 1'b0, dat_wen = 1'b0, pop_ready = 1'b0;
  logic [15:0] csr_wdata = '0;
  logic [7:0]  dat_wdata = '0;
  logic [15:0] csr_rdata;
  logic        pop_valid, irq;
  logic [7:0]  pop_data;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  txq_ctl uut (.clk(clk), .rst_n(rst_n), .csr_wen(csr_wen), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .dat_wen(dat_wen), .dat_wdata(dat_wdata),
    .pop_valid(pop_valid), .pop_data(pop_data), .pop_ready(pop_ready), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_csr(input logic [15:0] v);
    csr_wen = 1'b1; csr_wdata = v;
    @(negedge clk); csr_wen = 1'b0;
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    dat_wen = 1'b1; dat_wdata = b;
    @(negedge clk); dat_wen = 1'b0;
  endtask

  task automatic pop_exp(input string req, input logic [7:0] b);
    chk(req, pop_valid, 1'b1);
    chk(req, pop_data, b);
    pop_ready = 1'b1;
    @(negedge clk); pop_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 csr", csr_rdata, 16'h0000);
    chk("R1 irq", irq, 1'b0);
    chk("R1 valid", pop_valid, 1'b0);
  endtask

  task automatic t_flag;
    wr_csr(16'hFFFF);
    chk("R2 readback", csr_rdata, 16'h60BF);
    wr_csr(16'h6020);
    chk("R7 flag on release", csr_rdata[7], 1'b1);
    chk("R10 irq on", irq, 1'b1);
    wr_csr(16'h6060);
    chk("R9 set wins", csr_rdata[7], 1'b1);
    push(8'h11);
    @(negedge clk);
    chk("R3 count 1", csr_rdata[12:8], 5'd1);
    wr_csr(16'h6020);
    chk("R8 zero strobe", csr_rdata[7], 1'b1);
    wr_csr(16'h6000);
    chk("R10 gated", irq, 1'b0);
    chk("R10 flag kept", csr_rdata[7], 1'b1);
    wr_csr(16'h6060);
    chk("R8 cleared", csr_rdata[7], 1'b0);
    chk("R10 irq off", irq, 1'b0);
    pop_exp("R4 single", 8'h11);
    @(negedge clk);
    chk("R7 flag again", csr_rdata[7], 1'b1);
  endtask

  task automatic t_full;
    for (int i = 0; i < 17; i++) push(8'(8'hA0 + i));
    @(negedge clk);
    chk("R3 full count", csr_rdata[12:8], 5'd16);
    for (int i = 0; i < 16; i++) pop_exp("R4 order", 8'(8'hA0 + i));
    @(negedge clk);
    chk("R3 extra dropped", pop_valid, 1'b0);
    chk("R3 empty", csr_rdata[12:8], 5'd0);
  endtask

  task automatic t_both;
    push(8'h01); push(8'h02);
    dat_wen = 1'b1; dat_wdata = 8'h03; pop_ready = 1'b1;
    @(negedge clk); dat_wen = 1'b0; pop_ready = 1'b0;
    chk("R4 push+pop count", csr_rdata[12:8], 5'd2);
    pop_exp("R4 after both", 8'h02);
    pop_exp("R4 after both", 8'h03);
  endtask

  task automatic t_mode;
    push(8'h55); push(8'h66);
    wr_csr(16'h2000);
    chk("R5 valid low", pop_valid, 1'b0);
    push(8'h77);
    @(negedge clk);
    chk("R5 count kept", csr_rdata[12:8], 5'd2);
    wr_csr(16'h6000);
    pop_exp("R5 data kept", 8'h55);
    pop_exp("R5 data kept", 8'h66);
    chk("R5 write ignored", pop_valid, 1'b0);
  endtask

  task automatic t_hold;
    push(8'h91); push(8'h92); push(8'h93);
    wr_csr(16'h4000);
    chk("R6 count zero", csr_rdata[12:8], 5'd0);
    chk("R6 valid low", pop_valid, 1'b0);
    push(8'h94);
    wr_csr(16'h6000);
    chk("R6 discarded", pop_valid, 1'b0);
    chk("R6 count after", csr_rdata[12:8], 5'd0);
    push(8'h95);
    pop_exp("R6 restart", 8'h95);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_flag;
        t_full;
        t_both;
        t_mode;
        t_hold;
      end
      begin
        repeat (5000) @(negedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule